// File: doc/BRIEF.md
# Asynchronous SRAM Access Gate

This block sits between the asynchronous, active-low control pins of a byte-wide working memory and the clocked logic that drives that memory. It brings chip select, output enable, write enable and the hardware store request pin into the system clock domain. It then decides each cycle whether a read, a write or neither may happen, and presents the result as registered strobes: a read strobe, a write strobe and an output-drive enable for the data lines. It also presents a qualified hardware store request for the nonvolatile sequencer. The memory array itself and all analog timing lie outside the block.

Two system inputs shape the decision. A busy input from the store/recall sequencer silences all traffic while a nonvolatile cycle runs. A low-supply flag blocks every write and every store request while the supply is under the switch threshold. A rearm guard keeps a write from starting by accident when write select is already asserted at the end of a nonvolatile cycle or when reset is released. Such a write needs a fresh high-to-low transition on chip select or write enable. Each finished write raises a one-cycle done pulse, which the sequencer uses to mark the memory as modified.

Top module: `sram_access_gate`

## Requirements
- R1: `rd_stb` is high exactly when the synchronised pins show chip select low, output enable low, write enable high and store pin high, and `nv_busy` is low. It is never high together with `wr_stb`.
- R2: `wr_stb` is high exactly when chip select is low, write enable is low and the store pin is high, `nv_busy` and `low_supply` are low, and the rearm guard is clear.
- R3: `dq_oe` is high only during a read. Whenever write enable is low, `dq_oe` is low even if output enable is low.
- R4: While the store pin is low, neither `rd_stb` nor `wr_stb` is asserted.
- R5: A cycle after any cycle with `nv_busy` high, `rd_stb`, `wr_stb`, `dq_oe` and `hw_store_req` are all low.
- R6: A cycle after any cycle with `low_supply` high, `wr_stb` and `hw_store_req` are low. Reads are still served.
- R7: While chip select is high, `rd_stb`, `wr_stb` and `dq_oe` are low.
- R8: When `nv_busy` falls while chip select and write enable are both low, no write takes place until one of them has been seen high and then low again.
- R9: Reset leaves all outputs low. If chip select and write enable are both low when reset is released, the write is held off just as in R8.
- R10: Each write ends with `wr_done` high for exactly one cycle, in the first cycle that `wr_stb` is low again.
- R11: `hw_store_req` is high exactly while the store pin is low, `low_supply` is low and `nv_busy` is low.
- R12: A pin change made between clock edges reaches the registered outputs on the third rising edge after it: two synchroniser stages, then the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select pin, active low, asynchronous |
| oe_n | input | 1 | Output enable pin, active low, asynchronous |
| we_n | input | 1 | Write enable pin, active low, asynchronous |
| hs_n | input | 1 | Hardware store request pin, active low, asynchronous |
| nv_busy | input | 1 | Nonvolatile store or recall in progress, synchronous |
| low_supply | input | 1 | Supply below switch threshold, synchronous |
| rd_stb | output | 1 | Registered read strobe to the array |
| wr_stb | output | 1 | Registered write strobe to the array |
| dq_oe | output | 1 | Registered drive enable for the data outputs |
| wr_done | output | 1 | One-cycle pulse when a write ends |
| hw_store_req | output | 1 | Qualified hardware store request to the sequencer |

## Verification
The bound checker enforces the cycle-local rules on every cycle. These are read/write exclusion, drive being off during writes, silence one cycle after busy, the write and store block after low supply, the guard holding writes off, and the shape of the done pulse. The bench scenarios alone can show the rearm behaviour end to end: held off after a nonvolatile cycle and after reset, and released by a high-then-low move on chip select or write enable. They also show the exact three-edge pin latency and that the number of done pulses matches the number of writes under random pin, busy and supply patterns.

// File: rtl/sag_pkg.sv
package sag_pkg;

  // Synchronised view of the four control pins (all active low).
  typedef struct packed {
    logic hs_n;
    logic we_n;
    logic oe_n;
    logic ce_n;
  } pins_t;

  // Value the synchronisers hold in reset: select and enables asserted,
  // store pin idle, so that a write held at power-up sees no false edge.
  localparam pins_t PINS_RST = '{hs_n: 1'b1, we_n: 1'b0, oe_n: 1'b0, ce_n: 1'b0};

  function automatic logic rd_qual(input pins_t p);
    return !p.ce_n && !p.oe_n && p.we_n && p.hs_n;
  endfunction

  function automatic logic wr_qual(input pins_t p);
    return !p.ce_n && !p.we_n && p.hs_n;
  endfunction

  function automatic logic store_qual(input pins_t p);
    return !p.hs_n;
  endfunction

endpackage

// File: rtl/sag_sync.sv
module sag_sync #(
  parameter int          W      = 4,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sag_rearm.sv
module sag_rearm #(
  parameter logic CE_RST = 1'b0,
  parameter logic WE_RST = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,      // synchronised
  input  logic we_n,      // synchronised
  input  logic nv_busy,
  output logic hold_q,
  output logic hold_eff
);
  logic ce_d, we_d, busy_d;
  logic fresh_fall, nv_end, sel_idle;

  assign fresh_fall = (ce_d && !ce_n) || (we_d && !we_n);
  assign nv_end     = busy_d && !nv_busy;
  assign sel_idle   = ce_n || we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d   <= CE_RST;
      we_d   <= WE_RST;
      busy_d <= 1'b0;
      hold_q <= 1'b1;
    end else begin
      ce_d   <= ce_n;
      we_d   <= we_n;
      busy_d <= nv_busy;
      if (nv_end)                    hold_q <= 1'b1;
      else if (fresh_fall || sel_idle) hold_q <= 1'b0;
    end
  end

  // Block in the very cycle the nonvolatile cycle ends, before hold_q updates.
  assign hold_eff = hold_q || nv_end;
endmodule

// File: rtl/sram_access_gate.sv
module sram_access_gate
  import sag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic hs_n,
  input  logic nv_busy,
  input  logic low_supply,
  output logic rd_stb,
  output logic wr_stb,
  output logic dq_oe,
  output logic wr_done,
  output logic hw_store_req
);
  localparam int PIN_W = $bits(pins_t);

  pins_t raw_pins, syn_pins;
  logic  hold_q, hold_eff;
  logic  read_ok, write_ok, store_ok;

  assign raw_pins = '{hs_n: hs_n, we_n: we_n, oe_n: oe_n, ce_n: ce_n};

  sag_sync #(
    .W      (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST    (PINS_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_pins),
    .q     (syn_pins)
  );

  sag_rearm #(
    .CE_RST (PINS_RST.ce_n),
    .WE_RST (PINS_RST.we_n)
  ) u_rearm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (syn_pins.ce_n),
    .we_n     (syn_pins.we_n),
    .nv_busy  (nv_busy),
    .hold_q   (hold_q),
    .hold_eff (hold_eff)
  );

  // Named qualification events, visible to the bound checker.
  assign read_ok  = rd_qual(syn_pins) && !nv_busy;
  assign write_ok = wr_qual(syn_pins) && !nv_busy && !low_supply && !hold_eff;
  assign store_ok = store_qual(syn_pins) && !nv_busy && !low_supply;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb       <= 1'b0;
      wr_stb       <= 1'b0;
      dq_oe        <= 1'b0;
      wr_done      <= 1'b0;
      hw_store_req <= 1'b0;
    end else begin
      rd_stb       <= read_ok;
      wr_stb       <= write_ok;
      dq_oe        <= read_ok;
      wr_done      <= wr_stb && !write_ok;
      hw_store_req <= store_ok;
    end
  end
endmodule

module sram_access_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic nv_busy,
  input logic low_supply,
  input logic rd_stb,
  input logic wr_stb,
  input logic dq_oe,
  input logic wr_done,
  input logic hw_store_req,
  input logic hold_eff
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(rd_stb && wr_stb)); // R1
  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> !dq_oe); // R3
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nv_busy) |-> (!rd_stb && !wr_stb && !dq_oe && !hw_store_req)); // R5
  AST_LOW_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(low_supply) |-> (!wr_stb && !hw_store_req)); // R6
  AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n) $past(hold_eff) |-> !wr_stb); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) wr_done |=> !wr_done); // R10
  AST_DONE_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> ($past(wr_stb) && !wr_stb)); // R10
endmodule

bind sram_access_gate sram_access_gate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .nv_busy      (nv_busy),
  .low_supply   (low_supply),
  .rd_stb       (rd_stb),
  .wr_stb       (wr_stb),
  .dq_oe        (dq_oe),
  .wr_done      (wr_done),
  .hw_store_req (hw_store_req),
  .hold_eff     (hold_eff)
);

// File: tb/sram_access_gate_test.sv
module sram_access_gate_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b0, hs_n = 1'b1;
  logic nv_busy = 1'b0, low_supply = 1'b0;
  logic rd_stb, wr_stb, dq_oe, wr_done, hw_store_req;

  int nchecks = 0;
  int nfails  = 0;
  int done_cnt = 0;
  int exp_done = 0;
  bit hold_m = 1'b1;
  bit prev_wr = 1'b0;
  bit prev_done = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sram_access_gate uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .hs_n(hs_n),
    .nv_busy(nv_busy), .low_supply(low_supply), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .dq_oe(dq_oe), .wr_done(wr_done), .hw_store_req(hw_store_req)
  );

  function automatic bit e_rd(bit c, bit o, bit w, bit h, bit b);
    return (c == 0) && (o == 0) && (w == 1) && (h == 1) && (b == 0);
  endfunction
  function automatic bit e_wr(bit c, bit w, bit h, bit b, bit l, bit hold);
    return (c == 0) && (w == 0) && (h == 1) && !b && !l && !hold;
  endfunction
  function automatic bit e_st(bit h, bit b, bit l);
    return (h == 0) && !b && !l;
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    nchecks++;
    if (got !== exp) begin
      nfails++;
      $display("FAIL %s got=%0b expected=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all(string ctx);
    bit er, ew, es;
    er = e_rd(ce_n, oe_n, we_n, hs_n, nv_busy);
    ew = e_wr(ce_n, we_n, hs_n, nv_busy, low_supply, hold_m);
    es = e_st(hs_n, nv_busy, low_supply);
    chk({ctx, " R1 rd_stb"}, rd_stb, er);
    chk({ctx, " R2 wr_stb"}, wr_stb, ew);
    chk({ctx, " R3 dq_oe"}, dq_oe, er);
    chk({ctx, " R11 hw_store_req"}, hw_store_req, es);
    if (prev_wr && !ew) exp_done++;
    prev_wr = ew;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic apply_pins(bit c, bit o, bit w, bit h, string ctx);
    bit fall;
    @(negedge clk);
    fall = (ce_n && !c) || (we_n && !w);
    ce_n = c; oe_n = o; we_n = w; hs_n = h;
    settle();
    if (c || w || fall) hold_m = 1'b0;
    check_all(ctx);
  endtask

  task automatic apply_ctl(bit b, bit l, string ctx);
    bit fell;
    @(negedge clk);
    fell = nv_busy && !b;
    nv_busy = b; low_supply = l;
    settle();
    if (fell) hold_m = 1'b1;
    if (ce_n || we_n) hold_m = 1'b0;
    check_all(ctx);
  endtask

  // wr_done monitor: count pulses, check single-cycle width (R10)
  always @(posedge clk) begin
    if (rst_n) begin
      if (wr_done) begin
        done_cnt++;
        nchecks++;
        if (prev_done) begin
          nfails++;
          $display("FAIL R10 wr_done width got=2+ expected=1 at %0t", $time);
        end
      end
      prev_done = wr_done;
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      nfails++;
      $display("FAIL watchdog all-reqs got=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 reset rd_stb", rd_stb, 1'b0);
    chk("R9 reset wr_stb", wr_stb, 1'b0);
    chk("R9 reset dq_oe", dq_oe, 1'b0);
    chk("R9 reset wr_done", wr_done, 1'b0);
    chk("R9 reset hw_store_req", hw_store_req, 1'b0);
    rst_n = 1'b1;
    settle();
    check_all("R9 held after reset");
    apply_pins(0, 1, 1, 1, "R9 we high");
    apply_pins(0, 1, 0, 1, "R9 fresh we fall write");
    chk("R2 write active", wr_stb, 1'b1);

    // Reads and output drive
    apply_pins(0, 0, 1, 1, "R1 read");
    apply_pins(0, 0, 0, 1, "R3 we low oe low");
    chk("R3 drive off in write", dq_oe, 1'b0);
    apply_pins(0, 0, 0, 0, "R4 store pin low write");
    chk("R4 no write", wr_stb, 1'b0);
    apply_pins(0, 0, 1, 0, "R4 store pin low read");
    chk("R4 no read", rd_stb, 1'b0);
    apply_pins(1, 0, 0, 1, "R7 deselect");
    chk("R7 no drive", dq_oe, 1'b0);

    // R12 latency: ce falls with read setup
    apply_pins(1, 0, 1, 1, "R7 deselect read");
    @(negedge clk);
    ce_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R12 after two edges", rd_stb, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R12 after three edges", rd_stb, 1'b1);
    settle();
    check_all("R12 settled");

    // Low supply
    apply_pins(0, 1, 0, 1, "R2 write");
    apply_ctl(0, 1, "R6 low supply");
    chk("R6 write blocked", wr_stb, 1'b0);
    apply_pins(0, 1, 1, 0, "R6 store blocked");
    chk("R6 store blocked", hw_store_req, 1'b0);
    apply_pins(0, 0, 1, 1, "R6 read allowed");
    chk("R6 read served", rd_stb, 1'b1);
    apply_ctl(0, 0, "R6 supply ok");

    // Busy and rearm after nonvolatile cycle
    apply_pins(0, 1, 0, 1, "R2 write");
    apply_ctl(1, 0, "R5 busy");
    chk("R5 write blocked", wr_stb, 1'b0);
    apply_pins(0, 0, 1, 1, "R5 read during busy");
    chk("R5 read blocked", rd_stb, 1'b0);
    apply_pins(0, 1, 0, 1, "R5 write during busy");
    apply_ctl(0, 0, "R8 busy ends in write");
    chk("R8 write held", wr_stb, 1'b0);
    apply_pins(0, 1, 1, 1, "R8 we high");
    apply_pins(0, 1, 0, 1, "R8 we fall");
    chk("R8 write released", wr_stb, 1'b1);
    apply_ctl(1, 0, "R5 busy again");
    apply_ctl(0, 0, "R8 busy ends again");
    chk("R8 write held again", wr_stb, 1'b0);
    apply_pins(1, 1, 0, 1, "R8 ce high");
    apply_pins(0, 1, 0, 1, "R8 ce fall");
    chk("R8 released by ce", wr_stb, 1'b1);
    apply_pins(0, 1, 1, 1, "R10 end write");
    chk("R10 done count directed", 1'(done_cnt == exp_done), 1'b1);

    // Constrained random
    for (int i = 0; i < 200; i++) begin
      apply_ctl(($urandom % 5) == 0, ($urandom % 5) == 0, "rnd ctl");
      apply_pins(($urandom % 4) == 0, ($urandom % 2) == 0,
                 ($urandom % 2) == 0, ($urandom % 6) != 0, "rnd pins");
    end
    apply_ctl(0, 0, "rnd end");
    apply_pins(1, 1, 1, 1, "rnd idle");
    nchecks++;
    if (done_cnt != exp_done) begin
      nfails++;
      $display("FAIL R10 done count got=%0d expected=%0d", done_cnt, exp_done);
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchecks, nfails);
    $finish;
  end
endmodule